// File: doc/BRIEF.md
# Stepped Depression Window Scheduler

This block is one global controller shared by every plastic synapse of a learning neuron. It hands out the length of the depression window, which is how late a presynaptic spike may follow a postsynaptic spike and still weaken the synapse. The length is counted in 100 µs time-base ticks. The window is not fixed. It starts a little above the potentiation window and grows through a six-entry table as training goes on. The potentiation window is a build-time constant and passes through unchanged.

A pulse on `start` latches the adaptation period (in ticks) and starts the stage timer. The first stage lasts two periods and every later stage lasts one period. When the last stage is reached, the window holds its final value and `done` stays high until `clr`. Software can rewrite any table entry while the block is idle, for example to move the last entry from 35.6 ms to 38.6 ms for a quiet input. Writes made while the block is running are dropped.

Top module: `dep_window_sched`

## Requirements
- R1: After reset, `stage` is 0, `done` is 0 and `win_dep` is 103 (10.3 ms in 100 µs ticks).
- R2: Ticks have no effect until `start` is pulsed. A tick in the same cycle as `start` is not counted. A `start` while the block is running or done is ignored.
- R3: Stage 0 lasts exactly twice the latched period. `stage` becomes 1 on the clock edge that counts the 2·P-th tick after start.
- R4: Each of stages 1 to 4 lasts exactly P counted ticks. `stage` increases by one at a time.
- R5: `win_dep` always equals the table entry selected by `stage`. The reset contents of the table, by stage 0..5, are 103, 133, 183, 230, 282, 356 ticks.
- R6: `done` is 1 exactly when `stage` is 5. After that, `stage`, `win_dep` and `done` hold through further ticks until `clr`.
- R7: `clr` returns `stage` to 0, clears `done`, restarts the stage timer and stops the run. It takes priority over a tick that would advance the stage and over a `start` in the same cycle.
- R8: `period_in` is latched on an accepted `start`. A later change of `period_in` has no effect until the next start. A latched value of 0 acts as 1.
- R9: A write of `wr_val` to entry `wr_idx` takes effect only while the block is idle (not started, or cleared). It is dropped while running or done. Indices 6 and 7 are dropped.
- R10: `win_pot` is constantly 100 (10 ms).
- R11: Cycles without `tick` do not advance the stage timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base tick, one cycle per 100 µs |
| start | input | 1 | Starts the schedule and latches the period |
| clr | input | 1 | Returns to stage 0, idle |
| period_in | input | 16 | Adaptation period in ticks |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Table entry to write |
| wr_val | input | 10 | Window value in ticks |
| win_dep | output | 10 | Current depression window in ticks |
| win_pot | output | 10 | Constant potentiation window in ticks |
| stage | output | 3 | Current stage index |
| done | output | 1 | High once the last stage is reached |

## Verification
Clear and stage advance can fall in the same cycle. The bench drives `clr` together with the tick that would end a stage, and expects stage 0, with no one-cycle visit to the next stage. `start` and `clr` are also driven in the same cycle, and the bench then confirms that later ticks leave the block idle. Table writes are issued in the same cycle as `start` and while running. Each one is judged by the `win_dep` value seen when the schedule later reaches that entry.

// File: rtl/dwin_sched_pkg.sv
package dwin_sched_pkg;
   localparam int unsigned DW_WIN_W    = 10;
   localparam int unsigned DW_PER_W    = 16;
   localparam int unsigned DW_N_STAGES = 6;
   localparam int unsigned DW_POT_WIN  = 100;
   // entry 0 in the low bits; values in 100 us ticks
   localparam logic [DW_N_STAGES*DW_WIN_W-1:0] DW_DEF_TABLE =
      {10'd356, 10'd282, 10'd230, 10'd183, 10'd133, 10'd103};

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/dwin_stage_timer.sv
module dwin_stage_timer #(
   parameter int unsigned CW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          tick,
   input  logic [CW-1:0] limit,
   output logic          adv
);
   logic [CW-1:0] cnt_q;

   assign adv = en & tick & (cnt_q == (limit - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (adv)      cnt_q <= '0;
      else if (en & tick) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/dwin_table.sv
module dwin_table #(
   parameter int unsigned N     = 6,
   parameter int unsigned WW    = 10,
   parameter int unsigned IW    = 3,
   parameter logic [N*WW-1:0] DEF = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [WW-1:0] wr_val,
   input  logic [IW-1:0] rd_idx,
   output logic [WW-1:0] rd_val
);
   logic [WW-1:0] ent [N];

   for (genvar i = 0; i < N; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[i] <= DEF[i*WW +: WW];
         else if (wr_en && !lock && (wr_idx == IW'(i)))
            ent[i] <= wr_val;
      end
   end

   always_comb begin
      rd_val = ent[0];
      for (int i = 1; i < N; i++)
         if (rd_idx == IW'(i)) rd_val = ent[i];
   end
endmodule

// File: rtl/dep_window_sched.sv
module dep_window_sched
   import dwin_sched_pkg::*;
#(
   parameter int unsigned N_STAGES     = DW_N_STAGES,
   parameter int unsigned WIN_W        = DW_WIN_W,
   parameter int unsigned PER_W        = DW_PER_W,
   parameter int unsigned POT_WIN      = DW_POT_WIN,
   parameter bit          FIRST_DOUBLE = 1'b1,
   parameter logic [N_STAGES*WIN_W-1:0] DEF_WIN = DW_DEF_TABLE,
   localparam int unsigned IDX_W       = idx_width(N_STAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             clr,
   input  logic [PER_W-1:0] period_in,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIN_W-1:0] wr_val,
   output logic [WIN_W-1:0] win_dep,
   output logic [WIN_W-1:0] win_pot,
   output logic [IDX_W-1:0] stage,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_STAGES - 1);

   if (N_STAGES < 2) begin : g_chk_n
      $error("N_STAGES must be at least 2");
   end
   if (PER_W < 1 || WIN_W < 2) begin : g_chk_w
      $error("PER_W and WIN_W too small");
   end
   if (POT_WIN >= (1 << WIN_W)) begin : g_chk_pot
      $error("POT_WIN does not fit in WIN_W");
   end
   if (DEF_WIN[WIN_W-1:0] <= POT_WIN) begin : g_chk_first
      $error("first window must exceed potentiation window");
   end
   for (genvar i = 1; i < N_STAGES; i++) begin : g_chk_mono
      if (DEF_WIN[i*WIN_W +: WIN_W] <= DEF_WIN[(i-1)*WIN_W +: WIN_W]) begin : g_bad
         $error("default windows must increase");
      end
   end

   logic             running_q;
   logic [PER_W-1:0] per_q;
   logic [IDX_W-1:0] stage_q;
   logic             last;
   logic             cnt_en;
   logic             adv;
   logic [PER_W:0]   limit;

   assign last   = (stage_q == LAST);
   assign cnt_en = running_q & ~last;

   if (FIRST_DOUBLE) begin : g_first_dbl
      assign limit = (stage_q == '0) ? {per_q, 1'b0} : {1'b0, per_q};
   end else begin : g_first_eq
      assign limit = {1'b0, per_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         per_q     <= PER_W'(1);
         stage_q   <= '0;
      end else if (clr) begin
         running_q <= 1'b0;
         stage_q   <= '0;
      end else begin
         if (start && !running_q) begin
            running_q <= 1'b1;
            per_q     <= (period_in == '0) ? PER_W'(1) : period_in;
         end
         if (adv) stage_q <= stage_q + 1'b1;
      end
   end

   dwin_stage_timer #(.CW(PER_W + 1)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (cnt_en),
      .tick  (tick),
      .limit (limit),
      .adv   (adv)
   );

   dwin_table #(.N(N_STAGES), .WW(WIN_W), .IW(IDX_W), .DEF(DEF_WIN)) u_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .lock   (running_q),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_val (wr_val),
      .rd_idx (stage_q),
      .rd_val (win_dep)
   );

   assign win_pot = WIN_W'(POT_WIN);
   assign stage   = stage_q;
   assign done    = last;
endmodule

// File: rtl/dep_window_sched_chk.sv
module dep_window_sched_chk #(
   parameter int unsigned IDX_W    = 3,
   parameter int unsigned N_STAGES = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             tick,
   input logic [IDX_W-1:0] stage,
   input logic             done
);
   a_r7_clear_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (stage == '0 && !done));

   a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clr) |=> done);

   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (stage == $past(stage) || stage == $past(stage) + 1'b1));

   a_r11_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(stage));

   a_r6_stage_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(stage) < N_STAGES));
endmodule

bind dep_window_sched dep_window_sched_chk #(.IDX_W(IDX_W), .N_STAGES(N_STAGES)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .clr   (clr),
   .tick  (tick),
   .stage (stage),
   .done  (done)
);

// File: tb/dep_window_sched_tb_top.sv
module dep_window_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 6;
   localparam int IW = 3;
   localparam int WW = 10;
   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0, start = 1'b0, clr = 1'b0, wr_en = 1'b0;
   logic [PW-1:0] period_in = '0;
   logic [IW-1:0] wr_idx = '0;
   logic [WW-1:0] wr_val = '0;
   logic [WW-1:0] win_dep, win_pot;
   logic [IW-1:0] stage;
   logic          done;

   always #(CLK_PERIOD/2) clk = ~clk;

   dep_window_sched dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .clr(clr),
      .period_in(period_in), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
      .win_dep(win_dep), .win_pot(win_pot), .stage(stage), .done(done)
   );

   typedef struct packed {
      logic [IW-1:0] stage;
      logic [WW-1:0] win;
      logic          done;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];
   int    checks = 0, fails = 0;
   bit    finished = 1'b0;

   bit m_run = 1'b0;
   int m_stage = 0, m_cnt = 0, m_per = 1, cur_per = 3;
   int m_tab[N] = '{103, 133, 183, 230, 282, 356};

   task automatic cyc(bit t, bit s, bit c, bit we, int wi, int wv, string tag);
      int lim;
      exp_t e;
      @(negedge clk);
      tick = t; start = s; clr = c; wr_en = we;
      wr_idx = IW'(wi); wr_val = WW'(wv); period_in = PW'(cur_per);
      if (c) begin
         m_run = 1'b0; m_stage = 0; m_cnt = 0;
      end else begin
         if (we && !m_run && wi < N) m_tab[wi] = wv;
         if (!m_run) begin
            if (s) begin m_run = 1'b1; m_per = (cur_per == 0) ? 1 : cur_per; end
         end else if (t && m_stage < N-1) begin
            lim = (m_stage == 0) ? 2*m_per : m_per;
            if (m_cnt == lim-1) begin m_stage++; m_cnt = 0; end
            else m_cnt++;
         end
      end
      e.stage = IW'(m_stage);
      e.win   = WW'(m_tab[m_stage]);
      e.done  = (m_stage == N-1);
      expq.push_back(e);
      tagq.push_back(tag);
   endtask

   task automatic run_ticks(int n, string tag);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, tag);
   endtask

   // monitor: compares design outputs against queued expectations
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (expq.size() > 0) begin
            exp_t  e;
            string tg;
            e  = expq.pop_front();
            tg = tagq.pop_front();
            checks++;
            if (stage !== e.stage || win_dep !== e.win || done !== e.done) begin
               fails++;
               $display("FAIL %s: stage=%0d win=%0d done=%0b expected stage=%0d win=%0d done=%0b",
                        tg, stage, win_dep, done, e.stage, e.win, e.done);
            end
            if (win_pot !== WW'(100)) begin // R10
               fails++;
               $display("FAIL R10 (%s): win_pot=%0d expected 100", tg, win_pot);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_per = 3;
      cyc(0, 0, 0, 0, 0, 0, "R1");             // reset state
      run_ticks(3, "R2");                      // not started: no advance
      cyc(0, 0, 0, 1, 5, 386, "R9");           // idle write to last entry
      cyc(0, 0, 0, 1, 6, 999, "R9");           // out-of-range index dropped
      cyc(1, 1, 0, 1, 4, 290, "R2");           // start + tick + idle write
      run_ticks(5, "R3");                      // stage 0 still
      cyc(0, 0, 0, 1, 3, 77, "R9");            // write while running dropped
      cyc(0, 0, 0, 0, 0, 0, "R11");
      run_ticks(1, "R3");                      // 6th tick -> stage 1
      cur_per = 1;                             // R8: ignored mid-run
      cyc(0, 1, 0, 0, 0, 0, "R2");             // start while running ignored
      run_ticks(3, "R4");                      // -> stage 2
      cyc(0, 0, 0, 0, 0, 0, "R11");
      run_ticks(9, "R4");                      // -> stage 5
      run_ticks(4, "R6");                      // hold at last stage
      cyc(0, 0, 0, 1, 0, 50, "R9");            // write while done dropped
      cyc(0, 0, 1, 0, 0, 0, "R7");             // clear
      cyc(0, 0, 0, 1, 0, 120, "R9");           // idle write visible at stage 0
      cur_per = 0;
      cyc(0, 1, 0, 0, 0, 0, "R8");             // start with period 0 -> 1
      run_ticks(2, "R8");                      // -> stage 1
      run_ticks(1, "R8");                      // -> stage 2
      cur_per = 4;
      run_ticks(2, "R8");                      // -> stage 4
      cyc(1, 0, 1, 0, 0, 0, "R7");             // clear beats advancing tick
      cyc(1, 1, 1, 0, 0, 0, "R7");             // clear beats start
      run_ticks(3, "R7");                      // still idle
      cur_per = 2;
      cyc(0, 1, 0, 0, 0, 0, "R5");
      run_ticks(4, "R3");                      // first stage = 2*P
      run_ticks(12, "R5");                     // walk the table to the end
      run_ticks(2, "R6");
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule